// File: doc/BRIEF.md
# I2C Target Address Front-End with Strap-Selected Address

This block is the bus-facing half of an I2C target. It samples SCL and SDA with a fast system clock, cleans both lines and finds the bus conditions on them. It then takes in the first byte of each transfer and compares its upper seven bits with the device's own address. That address is fixed apart from three bits, which come from board-level strap inputs, so up to eight of these targets can share one bus.

On a match the block pulls SDA low in the ninth clock, reports the transfer direction and stays selected. In a write it hands each received byte to the core on a single-cycle valid/data port and acknowledges it. In a read it takes a byte from the core, signals that it has taken it, and shifts it out. It keeps doing so while the controller acknowledges each byte. The block only ever pulls SDA low through an open-drain enable.

Top module: `i2c_strap_target`

## Requirements
- R1: The own address, bits A6..A0, is 1, 0, strap_i[2], 0, strap_i[1], 0, strap_i[0]. The block acknowledges an address byte (SDA low in the ninth clock) only when its upper seven bits equal this value.
- R2: Bit 0 of the address byte is the direction: 0 means the controller writes and 1 means the controller reads. After a match, read_o carries this bit and active_o is 1.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Once an address has been acknowledged, a STOP deselects the block (active_o = 0). It then acknowledges no byte and emits no data until the next START.
- R4: While the address byte is being shifted in, START and STOP patterns on the bus are ignored. The byte still completes and is still acknowledged if it matches.
- R5: After a mismatched address the block leaves SDA released, gives no ACK and outputs no received bytes until the next START.
- R6: In a write, bytes are taken MSB first. rx_valid_o pulses for exactly one cycle with the byte on rx_data_o, and the block pulls SDA low in the ninth clock.
- R7: In a read, the block samples tx_data_i at the end of the previous acknowledge and pulses tx_take_o for one cycle. It drives that byte MSB first. When the controller acknowledges (SDA low in the ninth clock), it fetches and sends the next byte.
- R8: When the controller does not acknowledge a read byte, the block releases SDA, so any further clocks read 0xFF. It fetches no more bytes until a STOP or a START.
- R9: A repeated START after an acknowledged address begins a new address phase, which can select the other direction.
- R10: An SCL or SDA pulse that lasts fewer than FILT_LEN system clocks after synchronization has no effect on the bus state.
- R11: The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Strap inputs setting address bits A4, A2, A0 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| active_o | output | 1 | Block is addressed in the current transfer |
| read_o | output | 1 | Direction of the current transfer, 1 = controller reads |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte |
| tx_data_i | input | 8 | Next byte to send in a read |
| tx_take_o | output | 1 | One-cycle strobe: tx_data_i has been taken |

## Verification
A line change reaches the block's state after six system clocks: two synchronizer flops, three filter samples with FILT_LEN = 3, and the event/FSM register. So an SDA drive or release, an rx_valid_o strobe or a tx_take_o strobe is due six cycles after the SCL edge that causes it. The bench moves SDA and SCL only on quarter-bit boundaries of twelve clocks. It reads SDA in the middle of the SCL-high phase, and it reads ports and strobe counters at least one quarter after the causing edge, so every result has settled before it is sampled. The glitch checks use pulses of two clocks, one short of the filter length, and the address sweep covers all 64 pairs of strap value and addressed value.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int BCNT_W  = $clog2(BYTE_W) + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int   FILT_LEN  = 3,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN) + 1;

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= RESET_VAL;
      s2_q   <= RESET_VAL;
      filt_q <= RESET_VAL;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != filt_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic              active_o,
  output logic              read_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              tx_take_o
);
  tgt_state_e        state_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              mnack_q;
  logic              byte_done;

  assign byte_done = (bcnt_q == BCNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      shreg_q    <= '0;
      bcnt_q     <= '0;
      mnack_q    <= 1'b0;
      sda_oe_o   <= 1'b0;
      active_o   <= 1'b0;
      read_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      tx_take_o  <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_take_o  <= 1'b0;
      // conditions only honoured outside the address phase
      if (start_i && state_q != ST_ADDR) begin
        state_q  <= ST_ADDR;
        bcnt_q   <= '0;
        sda_oe_o <= 1'b0;
        active_o <= 1'b0;
      end else if (stop_i && state_q != ST_ADDR) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
        active_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
              bcnt_q  <= bcnt_q + 1'b1;
            end else if (scl_fall_i && byte_done) begin
              bcnt_q <= '0;
              if (shreg_q[BYTE_W-1:1] == own_addr_i) begin
                sda_oe_o <= 1'b1;
                active_o <= 1'b1;
                read_o   <= shreg_q[0];
                state_q  <= ST_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bcnt_q <= '0;
              if (read_o) begin
                shreg_q   <= tx_data_i;
                sda_oe_o  <= ~tx_data_i[BYTE_W-1];
                tx_take_o <= 1'b1;
                state_q   <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
              bcnt_q  <= bcnt_q + 1'b1;
            end else if (scl_fall_i && byte_done) begin
              rx_valid_o <= 1'b1;
              rx_data_o  <= shreg_q;
              sda_oe_o   <= 1'b1;
              state_q    <= ST_ACK;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              bcnt_q <= bcnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (byte_done) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RD_ACK;
              end else begin
                shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~shreg_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mnack_q <= sda_i;
            end else if (scl_fall_i) begin
              bcnt_q <= '0;
              if (!mnack_q) begin
                shreg_q   <= tx_data_i;
                sda_oe_o  <= ~tx_data_i[BYTE_W-1];
                tx_take_o <= 1'b1;
                state_q   <= ST_RD;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int                FILT_LEN  = 3,
  parameter int                N_STRAP   = 3,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b100_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [N_STRAP-1:0] strap_i,
  output logic               sda_oe_o,
  output logic               active_o,
  output logic               read_o,
  output logic               rx_valid_o,
  output logic [BYTE_W-1:0]  rx_data_o,
  input  logic [BYTE_W-1:0]  tx_data_i,
  output logic               tx_take_o
);
  logic [1:0]        raw_lines, filt_lines;
  logic              scl_f, sda_f;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN), .RESET_VAL(1'b1)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_lines[g]),
      .filt_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  // straps land on every other address bit from A0 upward
  always_comb begin
    own_addr = ADDR_BASE;
    for (int k = 0; k < N_STRAP; k++) own_addr[2*k] = strap_i[k];
  end

  i2c_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_tgt_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .own_addr_i(own_addr),
    .sda_i     (sda_f),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .tx_data_i (tx_data_i),
    .sda_oe_o  (sda_oe_o),
    .active_o  (active_o),
    .read_o    (read_o),
    .rx_valid_o(rx_valid_o),
    .rx_data_o (rx_data_o),
    .tx_take_o (tx_take_o)
  );
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic sda_oe_o,
  input logic active_o,
  input logic read_o,
  input logic rx_valid_o,
  input logic tx_take_o
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_f)); // R11

  AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !sda_oe_o); // R5

  AST_RX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R6

  AST_RX_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (active_o && !read_o)); // R2

  AST_TAKE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_o |-> (active_o && read_o)); // R7

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_o |=> !tx_take_o); // R7
endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_f     (scl_f),
  .sda_oe_o  (sda_oe_o),
  .active_o  (active_o),
  .read_o    (read_o),
  .rx_valid_o(rx_valid_o),
  .tx_take_o (tx_take_o)
);

// File: tb/test_i2c_strap_target.sv
module test_i2c_strap_target;
  localparam int Q = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       sda_oe, active, rd_dir, rx_valid, tx_take;
  logic [7:0] rx_data, tx_data;
  logic       sda_line;

  int checks = 0, errs = 0;
  int rx_cnt = 0, take_cnt = 0, drive_viol = 0;
  logic [7:0] rx_last = '0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [7:0] patt(input int n);
    return 8'(n * 53 + 154);
  endfunction

  function automatic logic [6:0] own(input logic [2:0] s);
    return {1'b1, 1'b0, s[2], 1'b0, s[1], 1'b0, s[0]};
  endfunction

  assign tx_data = patt(take_cnt);

  i2c_strap_target i_i2c_strap_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .active_o(active), .read_o(rd_dir),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .tx_data_i(tx_data),
    .tx_take_o(tx_take)
  );

  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (tx_take) take_cnt <= take_cnt + 1;
    if (sda_oe && !oe_prev && scl_m) drive_viol <= drive_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    qwait(); sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic scl_low(); qwait(); scl_m = 1'b0; endtask

  task automatic wr_bit(input logic b, input bit glitch, input bit scl_gl);
    qwait(); sda_m = b;
    if (scl_gl) begin
      repeat (3) @(negedge clk); scl_m = 1'b1;
      repeat (2) @(negedge clk); scl_m = 1'b0;
    end
    qwait(); scl_m = 1'b1; qwait();
    if (glitch) sda_m = ~b;
    qwait(); scl_m = 1'b0;
  endtask

  task automatic rd_bit(output logic v);
    qwait(); sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); v = sda_line; qwait(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic [7:0] gl, input logic [7:0] sgl,
                           output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) wr_bit(d[i], gl[i], sgl[i]);
    rd_bit(v);
    ack = !v;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin rd_bit(v); d[i] = v; end
    wr_bit(!mack, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    bit         ack;
    int         rc, t0;
    logic [7:0] d;
    logic [6:0] a;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sda_oe && !active && !rx_valid && !tx_take, "reset R5", {sda_oe, active}, 0);

    // R1 / R5 sweep over all strap values and addressed values
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int c = 0; c < 8; c++) begin
        bus_start();
        send_byte({own(3'(c)), 1'b0}, 8'h00, 8'h00, ack);
        chk(ack == (c == s), "R1 address match", int'(ack), int'(c == s));
        if (c != s) begin
          rc = rx_cnt;
          send_byte(8'h00, 8'h00, 8'h00, ack);
          chk(!ack && rx_cnt == rc && !active, "R5 ignored after mismatch", int'(ack), 0);
        end
        bus_stop();
      end
    end

    // R1 fixed bits must match
    strap = 3'b101;
    for (int k = 1; k < 7; k += 2) begin
      for (int j = 0; j < 2; j++) begin
        int bitpos = (j == 0) ? k : ((k == 1) ? 6 : k + 2);
        if (bitpos > 6) continue;
        a = own(strap) ^ 7'(1 << bitpos);
        bus_start();
        send_byte({a, 1'b0}, 8'h00, 8'h00, ack);
        chk(!ack, "R1 fixed bit mismatch", int'(ack), 0);
        bus_stop();
      end
    end

    // R2 R6 R10 write, then R9 repeated start into read
    bus_start();
    send_byte({own(strap), 1'b0}, 8'h00, 8'h00, ack);
    chk(ack && active && !rd_dir, "R2 write selected", {ack, active, rd_dir}, 3'b110);
    rc = rx_cnt;
    send_byte(8'hA5, 8'h00, 8'h00, ack);
    chk(ack && rx_cnt == rc + 1 && rx_last == 8'hA5, "R6 write byte", rx_last, 8'hA5);
    send_byte(8'h3C, 8'h00, 8'b0001_0100, ack);
    chk(ack && rx_cnt == rc + 2 && rx_last == 8'h3C, "R10 scl glitch filtered", rx_last, 8'h3C);
    bus_start();
    send_byte({own(strap), 1'b1}, 8'h00, 8'h00, ack);
    chk(ack && active && rd_dir, "R9 repeated start read", {ack, active, rd_dir}, 3'b111);
    t0 = take_cnt;
    recv_byte(1'b0, d);
    chk(d == patt(t0) && take_cnt == t0 + 1, "R9 read after restart", d, patt(t0));
    bus_stop();

    // R7 R8 read sequence
    bus_start();
    send_byte({own(strap), 1'b1}, 8'h00, 8'h00, ack);
    chk(ack && rd_dir, "R2 read selected", int'(rd_dir), 1);
    t0 = take_cnt;
    recv_byte(1'b1, d);
    chk(d == patt(t0), "R7 first read byte", d, patt(t0));
    recv_byte(1'b0, d);
    chk(d == patt(t0 + 1), "R7 acked next byte", d, patt(t0 + 1));
    recv_byte(1'b0, d);
    chk(d == 8'hFF && !sda_oe, "R8 released after nack", d, 8'hFF);
    chk(take_cnt == t0 + 2, "R8 no fetch after nack", take_cnt, t0 + 2);
    bus_stop();

    // R3 stop deselects
    bus_start();
    send_byte({own(strap), 1'b0}, 8'h00, 8'h00, ack);
    chk(ack, "R3 address before stop", int'(ack), 1);
    bus_stop();
    chk(!active, "R3 stop deselects", int'(active), 0);
    scl_low();
    rc = rx_cnt;
    send_byte(8'h77, 8'h00, 8'h00, ack);
    chk(!ack && rx_cnt == rc, "R3 no ack after stop", int'(ack), 0);
    bus_stop();

    // R4 conditions inside address phase ignored (bit7 = 1 gets START, bit6 = 0 gets STOP)
    bus_start();
    send_byte({own(strap), 1'b0}, 8'b1100_0000, 8'h00, ack);
    chk(ack && active, "R4 conditions ignored in address", int'(ack), 1);
    rc = rx_cnt;
    send_byte(8'h5A, 8'h00, 8'h00, ack);
    chk(ack && rx_cnt == rc + 1 && rx_last == 8'h5A, "R4 transfer continues", rx_last, 8'h5A);
    bus_stop();

    // R11 drive starts only with SCL low
    chk(drive_viol == 0, "R11 drive while scl low", drive_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule